// File: doc/BRIEF.md
# Sectored Direct-Mapped Cache

This block is a direct-mapped cache placed between a processor and a memory whose transfer unit is narrower than a cache line. Each line is split into sectors, and one sector is exactly one memory transfer. The directory keeps a single address tag per line, so its cost stays small. Each sector has its own presence bit, so a miss moves only one transfer unit across the memory port and never a whole line.

The processor side takes read and write requests. Each request carries a sector-granular address, split from top to bottom into tag, line index and sector number, and one sector of data. A read whose tag matches and whose sector is present returns its data on the following cycle.

A read that finds a foreign tag claims the line for the new tag, drops every sector of the old occupant and fetches only the requested sector. A read that finds the right tag but an absent sector fetches just that sector and leaves the rest of the line as it was. Stores are written through to memory. A store updates the cached copy only when its sector is present, and it never allocates.

Top module: `sectored_cache`

## Requirements
- R1: After reset the processor port is ready (`cpu_ready`=1), `cpu_rvalid`=0, `mem_req`=0, every tag reads as zero and every sector is absent, so the first read of any address misses.
- R2: A read whose tag equals the stored tag of its line and whose sector is present raises `cpu_rvalid` for one cycle, on the cycle after acceptance, with the stored data, and makes no memory request.
- R3: A read whose tag differs from the stored tag issues exactly one memory read (`mem_we`=0) whose address equals the processor address, sector number included.
- R4: A fill completes on the cycle `mem_ack` is high. On the next cycle `cpu_rvalid` is 1 with `cpu_rdata` equal to that cycle's `mem_rdata`, and the sector is present from then on.
- R5: A read with a matching tag but an absent sector fetches only that sector (one memory read), and the sectors already present in the line stay present.
- R6: A read that replaces the tag of a line marks all sectors of that line absent before the requested sector is loaded, so no other sector under the new tag hits until it is fetched.
- R7: A write is sent to memory once, with the same address and data. If its sector is present, the cached copy takes the new data and later reads hit with it.
- R8: A write to an absent sector or to a foreign tag updates memory only: the sector stays absent, and the tag and sectors of the line are unchanged.
- R9: From accepting a miss or a write until the cycle after `mem_ack`, `cpu_ready` is 0, and `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until acknowledged.
- R10: Address fields: the sector number is `addr[log2(SECTORS)-1:0]`, the line index is the next log2(LINES) bits, and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Sector address {tag, index, sector} |
| cpu_wdata | input | DATA_W | Write data, one sector |
| cpu_ready | output | 1 | Cache idle and able to take a request |
| cpu_rvalid | output | 1 | One-cycle read response strobe |
| cpu_rdata | output | DATA_W | Read response data |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = sector fetch |
| mem_addr | output | ADDR_W | Sector address of the transfer |
| mem_wdata | output | DATA_W | Write-through data |
| mem_ack | input | 1 | Transfer complete, one cycle |
| mem_rdata | input | DATA_W | Fetched sector, valid with `mem_ack` |

## Verification
The hardest case to reach is a stale sector: a line that already holds present sectors under one tag is claimed by another tag, and a sector that was present under the old tag is then read under the new one. A design that keeps the old presence bits answers that read as a hit with wrong data. The bench sets this up directly, by filling two sectors of a line under one tag and then switching tags in the same line. It then sweeps pseudo-random mixed traffic confined to a few tags, so that tag replacement, partial lines and writes to absent sectors occur many times over, each compared against an arithmetic shadow of tags, presence bits and memory contents.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [1:0] {
      SC_IDLE  = 2'd0,
      SC_FILL  = 2'd1,
      SC_WRITE = 2'd2
   } sc_state_e;
endpackage

// File: rtl/sc_directory.sv
module sc_directory #(
   parameter int LINES   = 64,
   parameter int SECTORS = 4,
   parameter int TAG_W   = 18,
   localparam int IDX_W  = $clog2(LINES),
   localparam int SEC_W  = $clog2(SECTORS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [TAG_W-1:0]   rd_tag,
   output logic [SECTORS-1:0] rd_present,
   input  logic               claim_en,
   input  logic [IDX_W-1:0]   claim_idx,
   input  logic [TAG_W-1:0]   claim_tag,
   input  logic               mark_en,
   input  logic [IDX_W-1:0]   mark_idx,
   input  logic [SEC_W-1:0]   mark_sec
);
   logic [LINES*TAG_W-1:0]   tags_flat;
   logic [LINES*SECTORS-1:0] pres_flat;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [TAG_W-1:0]   tag_q;
      logic [SECTORS-1:0] pres_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q  <= '0;
            pres_q <= '0;
         end else if (claim_en && claim_idx == IDX_W'(i)) begin
            tag_q  <= claim_tag;
            pres_q <= '0;
         end else if (mark_en && mark_idx == IDX_W'(i)) begin
            pres_q[mark_sec] <= 1'b1;
         end
      end
      assign tags_flat[i*TAG_W +: TAG_W]     = tag_q;
      assign pres_flat[i*SECTORS +: SECTORS] = pres_q;
   end

   assign rd_tag     = tags_flat[rd_idx*TAG_W +: TAG_W];
   assign rd_present = pres_flat[rd_idx*SECTORS +: SECTORS];
endmodule

// File: rtl/sc_sector_store.sv
module sc_sector_store #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 128,
   localparam int SLOT_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [SLOT_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SLOT_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells_q[waddr] <= wdata;
   end

   assign rdata = cells_q[raddr];
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
   import sc_pkg::*;
#(
   parameter int ADDR_W = 28,
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              lookup_hit,
   input  logic              mem_ack,
   output logic              cpu_ready,
   output logic              rd_hit_go,
   output logic              rd_miss_go,
   output logic              wr_go,
   output logic              fill_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   sc_state_e         state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              take;

   assign cpu_ready  = (state_q == SC_IDLE);
   assign take       = cpu_req && cpu_ready;
   assign rd_hit_go  = take && !cpu_we && lookup_hit;
   assign rd_miss_go = take && !cpu_we && !lookup_hit;
   assign wr_go      = take && cpu_we;
   assign fill_done  = (state_q == SC_FILL) && mem_ack;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SC_IDLE: begin
            if (wr_go)           state_d = SC_WRITE;
            else if (rd_miss_go) state_d = SC_FILL;
         end
         SC_FILL, SC_WRITE: begin
            if (mem_ack) state_d = SC_IDLE;
         end
         default: state_d = SC_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SC_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (take) begin
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
         end
      end
   end

   assign mem_req   = (state_q != SC_IDLE);
   assign mem_we    = (state_q == SC_WRITE);
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
endmodule

// File: rtl/sectored_cache.sv
module sectored_cache #(
   parameter int ADDR_W  = 28,
   parameter int DATA_W  = 128,
   parameter int LINES   = 64,
   parameter int SECTORS = 4,
   localparam int SEC_W  = $clog2(SECTORS),
   localparam int IDX_W  = $clog2(LINES),
   localparam int SLOT_W = IDX_W + SEC_W,
   localparam int TAG_W  = ADDR_W - SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_rvalid,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   if (SECTORS < 2 || (1 << SEC_W) != SECTORS) begin : g_bad_sectors
      $error("SECTORS must be a power of two, at least 2");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   logic [TAG_W-1:0]   cpu_tag, fill_tag_unused, rd_tag;
   logic [IDX_W-1:0]   cpu_idx, fill_idx;
   logic [SEC_W-1:0]   cpu_sec, fill_sec;
   logic [SECTORS-1:0] rd_present;
   logic               tag_match, lookup_hit;
   logic               rd_hit_go, rd_miss_go, wr_go, fill_done;
   logic               store_we;
   logic [SLOT_W-1:0]  store_waddr;
   logic [DATA_W-1:0]  store_wdata, store_rdata;
   logic               rvalid_q;
   logic [DATA_W-1:0]  rdata_q;

   assign {cpu_tag, cpu_idx, cpu_sec}          = cpu_addr;
   assign {fill_tag_unused, fill_idx, fill_sec} = mem_addr;

   assign tag_match  = (rd_tag == cpu_tag);
   assign lookup_hit = tag_match && rd_present[cpu_sec];

   sc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .lookup_hit(lookup_hit), .mem_ack(mem_ack),
      .cpu_ready(cpu_ready), .rd_hit_go(rd_hit_go), .rd_miss_go(rd_miss_go),
      .wr_go(wr_go), .fill_done(fill_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   sc_directory #(.LINES(LINES), .SECTORS(SECTORS), .TAG_W(TAG_W)) dir_i (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(cpu_idx), .rd_tag(rd_tag), .rd_present(rd_present),
      .claim_en(rd_miss_go && !tag_match), .claim_idx(cpu_idx), .claim_tag(cpu_tag),
      .mark_en(fill_done), .mark_idx(fill_idx), .mark_sec(fill_sec)
   );

   assign store_we    = (wr_go && lookup_hit) || fill_done;
   assign store_waddr = fill_done ? {fill_idx, fill_sec} : {cpu_idx, cpu_sec};
   assign store_wdata = fill_done ? mem_rdata : cpu_wdata;

   sc_sector_store #(.DEPTH(LINES * SECTORS), .DATA_W(DATA_W)) store_i (
      .clk(clk), .we(store_we), .waddr(store_waddr), .wdata(store_wdata),
      .raddr({cpu_idx, cpu_sec}), .rdata(store_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= rd_hit_go || fill_done;
         if (rd_hit_go)      rdata_q <= store_rdata;
         else if (fill_done) rdata_q <= mem_rdata;
      end
   end

   assign cpu_rvalid = rvalid_q;
   assign cpu_rdata  = rdata_q;
endmodule

// File: rtl/sectored_cache_chk.sv
module sectored_cache_chk #(
   parameter int ADDR_W = 28,
   parameter int DATA_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_ready,
   input logic              cpu_rvalid,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              lookup_hit
);
   a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready && !cpu_we && lookup_hit |=> cpu_rvalid && !mem_req);

   a_r3_miss_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready && !cpu_we && !lookup_hit |=>
         mem_req && !mem_we && mem_addr == $past(cpu_addr));

   a_r4_fill_return: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && mem_ack |=> cpu_rvalid && cpu_rdata == $past(mem_rdata));

   a_r7_write_through: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready && cpu_we |=>
         mem_req && mem_we && mem_addr == $past(cpu_addr) && mem_wdata == $past(cpu_wdata));

   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);

   a_r9_req_steady: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));
endmodule

bind sectored_cache sectored_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
   .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
   .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
   .lookup_hit(lookup_hit)
);

// File: tb/sectored_cache_tb_top.sv
module sectored_cache_tb_top;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready, cpu_rvalid, mem_req, mem_we;
   logic [DW-1:0] cpu_rdata, mem_wdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   always #4 clk = ~clk;

   sectored_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(4), .SECTORS(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int tests = 0, fails = 0;
   int reads_n = 0, writes_n = 0;
   int lat_cnt = 0;
   bit done = 0;
   logic [DW-1:0] model [256];
   logic [3:0]    sh_tag [4];
   logic [3:0]    sh_val [4];

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (lat_cnt == LAT) begin
            lat_cnt <= 0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               model[mem_addr] <= mem_wdata;
               writes_n <= writes_n + 1;
            end else begin
               mem_rdata <= model[mem_addr];
               reads_n <= reads_n + 1;
            end
         end else lat_cnt <= lat_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, input string lbl);
      bit exp_hit, tm;
      int r0;
      string l;
      tm = (sh_tag[a[3:2]] == a[7:4]);
      exp_hit = tm && sh_val[a[3:2]][a[1:0]];
      l = (lbl != "") ? lbl : (exp_hit ? "R2" : (tm ? "R5" : "R3"));
      r0 = reads_n;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      @(negedge clk);
      cpu_req = 1'b0;
      if (!exp_hit) begin
         chk(!cpu_ready && mem_req && !mem_we && mem_addr == a, "R9", {mem_req, mem_we, mem_addr}, {2'b10, a});
         while (!cpu_rvalid) @(negedge clk);
      end
      chk(cpu_rvalid, l, 32'(cpu_rvalid), 1);
      chk(cpu_rdata == model[a], "R4", cpu_rdata, model[a]);
      chk(reads_n - r0 == (exp_hit ? 0 : 1), l, reads_n - r0, exp_hit ? 0 : 1);
      if (!tm) begin
         sh_tag[a[3:2]] = a[7:4];
         sh_val[a[3:2]] = '0;
      end
      sh_val[a[3:2]][a[1:0]] = 1'b1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string lbl);
      bit exp_hit;
      int r0, w0;
      string l;
      exp_hit = (sh_tag[a[3:2]] == a[7:4]) && sh_val[a[3:2]][a[1:0]];
      l = (lbl != "") ? lbl : (exp_hit ? "R7" : "R8");
      r0 = reads_n; w0 = writes_n;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0;
      chk(!cpu_ready && mem_req && mem_we && mem_addr == a && mem_wdata == d, "R9", mem_wdata, d);
      while (!cpu_ready) @(negedge clk);
      chk(writes_n - w0 == 1 && reads_n == r0, l, writes_n - w0, 1);
      chk(model[a] == d, l, model[a], d);
   endtask

   initial begin
      for (int i = 0; i < 256; i++)
         model[i] = {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A, 8'hC3};
      for (int i = 0; i < 4; i++) begin sh_tag[i] = '0; sh_val[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle reset state
      chk(cpu_ready && !cpu_rvalid && !mem_req, "R1", {cpu_ready, cpu_rvalid, mem_req}, 3'b100);
      rd(8'h35, "R1");
      // R5: second sector under matching tag, first stays present
      rd(8'h36, "R5");
      rd(8'h35, "R5");
      // R6: claim a line that holds present sectors, then read them under the new tag
      rd(8'h10, ""); rd(8'h11, "");
      rd(8'h22, "R3");
      rd(8'h20, "R6"); rd(8'h21, "R6");
      rd(8'h22, "R2");
      // R7: write hit updates cache and memory
      wr(8'h22, 32'hDEAD_0022, "R7");
      rd(8'h22, "R7");
      // R8: write to absent sector of resident line, and to a foreign tag
      wr(8'h23, 32'hBEEF_0023, "R8");
      rd(8'h23, "R8");
      wr(8'h30, 32'hCAFE_0030, "R8");
      rd(8'h22, "R8");
      rd(8'h20, "R8");
      // R10: sweep all addresses in order, fields decoded as tag/index/sector
      for (int a = 0; a < 256; a++) rd(8'(a), "R10");
      // mixed traffic over a few tags
      begin
         logic [15:0] lf = 16'hACE1;
         for (int n = 0; n < 1500; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[2:0] < 3'd3) wr({2'b00, lf[9:4]}, {lf, ~lf}, "");
            else                rd({2'b00, lf[9:4]}, "");
         end
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule